// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block moves outgoing frames from memory to a byte stream. Software builds a ring of 16-byte descriptors in memory and programs the ring base address. It then rings a doorbell. The engine reads the descriptor at its current ring position. If hardware owns that descriptor, the engine reads the referenced buffer one 32-bit word at a time. It presents the buffer as bytes on a valid/ready stream, with short frames padded out to the minimum frame size. Afterwards it writes the status word back with the ownership bit cleared and raises a completion flag.

The engine keeps walking the ring after each frame. It stops when it finds a descriptor that software still owns, and then waits for the next doorbell. A descriptor flagged as the end of the ring sends the position back to the first entry. A descriptor that does not describe a complete single-buffer frame is handed back to software without sending any bytes, and the error flag is raised. The descriptor and buffer memory sit behind one synchronous read/write port with a read latency of one cycle.

Top module: `txd_poll_engine`

## Requirements
- R1: After a synchronous reset, `tx_valid` and `mem_en` are low, `int_status` is zero and the ring position is entry 0.
- R2: A register write to offset 0x38 with data bit 6 set (value 0x40) starts a ring walk. A write to that offset with bit 6 clear starts nothing: no memory access and no byte is produced.
- R3: Register offsets 0x20 and 0x24 hold the low and high 32 bits of the ring base. The low 8 bits of a base write are ignored, giving 256-byte alignment. A base-low write while the engine is idle returns the ring position to entry 0. Entry i sits at base + 16*i. In each entry, the word at +0 is status, +4 is a tag word the engine does not use, +8 is the buffer address low word and +12 is the buffer address high word. All memory accesses are 32-bit and word aligned.
- R4: Status bit 31 marks hardware ownership. If the current entry has bit 31 clear, the engine returns to idle with no bytes, no write and no flag, and the ring position stays where it was.
- R5: For a valid owned entry, the bytes at buffer address, address+1, and so on appear in order on `tx_data`. Byte address bits [1:0] select memory word bits [8k+7:8k] (little-endian). `tx_valid`, `tx_data` and `tx_last` hold steady while `tx_ready` is low, and `tx_last` marks only the final byte.
- R6: Status bits [15:0] give the frame length in bytes. A length under 60 is sent as 60 bytes, with zero bytes after the real data.
- R7: Right after the last byte is accepted, the engine writes the status word back with bit 31 cleared and all other bits unchanged, and sets `int_status` bit 2 (transmit done).
- R8: An owned entry is accepted only if both status bit 29 (first segment) and bit 28 (last segment) are set. Any other combination sends no bytes, writes the status back with bit 31 cleared and sets `int_status` bit 3 (transmit error), not bit 2.
- R9: After handing back an entry, the engine moves to the next entry and keeps going. An entry with status bit 30 (end of ring) set sends the position back to entry 0.
- R10: A register write to offset 0x3E clears each `int_status` bit whose data bit is 1. A completion event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| int_status | output | 16 | Event flags: bit 2 transmit done, bit 3 transmit error |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 64 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the engine with its default position width of 8 bits and uses a four-entry ring, so every wrap and end-of-ring case comes up within a few frames. It sweeps frame lengths around the 60-byte pad boundary and around word boundaries against all four buffer byte alignments. It does this with and without back-pressure, which covers every lane-select and refetch point of the byte path. A nonzero upper base word is programmed and checked on every access, so the full 64-bit address path is exercised.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int ADDR_W      = 64;
    localparam int LEN_W       = 16;
    localparam int MIN_FRAME   = 60;
    localparam int ALIGN_BITS  = 8;

    localparam int OWN_BIT     = 31;
    localparam int EOR_BIT     = 30;
    localparam int FS_BIT      = 29;
    localparam int LS_BIT      = 28;

    localparam logic [7:0] OFS_BASE_LO = 8'h20;
    localparam logic [7:0] OFS_BASE_HI = 8'h24;
    localparam logic [7:0] OFS_POLL    = 8'h38;
    localparam logic [7:0] OFS_ISR     = 8'h3E;
    localparam int POLL_BIT    = 6;
    localparam int ISR_OK_BIT  = 2;
    localparam int ISR_ERR_BIT = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_STAT, S_CAP_STAT, S_RD_LO, S_CAP_LO,
        S_RD_HI, S_CAP_HI, S_FETCH, S_LOAD, S_SEND, S_WB
    } eng_state_t;

    function automatic logic [7:0] pick_lane(input logic [31:0] w, input logic [1:0] sel);
        return w[{sel, 3'b000} +: 8];
    endfunction

    function automatic logic [LEN_W-1:0] pad_len(input logic [LEN_W-1:0] n);
        return (n < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : n;
    endfunction

    function automatic logic seg_ok(input logic [31:0] st);
        return st[FS_BIT] && st[LS_BIT];
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              ok_evt,
    input  logic              err_evt,
    input  logic              take_poll,
    output logic [ADDR_W-1:0] base,
    output logic              base_set,
    output logic              poll_pend,
    output logic [15:0]       isr
);
    logic [31:0] base_lo, base_hi;
    logic        ok_q, err_q;
    logic        isr_wr;

    assign base_set = wr && (addr == OFS_BASE_LO);
    assign isr_wr   = wr && (addr == OFS_ISR);
    assign base     = {base_hi, base_lo};

    always_comb begin
        isr = '0;
        isr[ISR_OK_BIT]  = ok_q;
        isr[ISR_ERR_BIT] = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo   <= '0;
            base_hi   <= '0;
            poll_pend <= 1'b0;
            ok_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (base_set)
                base_lo <= {wdata[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            if (wr && addr == OFS_BASE_HI)
                base_hi <= wdata;
            if (wr && addr == OFS_POLL && wdata[POLL_BIT])
                poll_pend <= 1'b1;
            else if (take_poll)
                poll_pend <= 1'b0;
            if (ok_evt)
                ok_q <= 1'b1;
            else if (isr_wr && wdata[ISR_OK_BIT])
                ok_q <= 1'b0;
            if (err_evt)
                err_q <= 1'b1;
            else if (isr_wr && wdata[ISR_ERR_BIT])
                err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic              base_set,
    input  logic              poll_pend,
    output logic              take_poll,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              ok_evt,
    output logic              err_evt
);
    localparam int DESC_SHIFT = 4;

    eng_state_t        st;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       stat_q, blo_q, word_q;
    logic [ADDR_W-1:0] buf_q, desc_addr, cur_byte;
    logic [LEN_W-1:0]  pos, next_pos, raw_len, frame_len;
    logic              in_data;

    assign desc_addr = base + ADDR_W'({idx, {DESC_SHIFT{1'b0}}});
    assign cur_byte  = buf_q + ADDR_W'(pos);
    assign raw_len   = stat_q[LEN_W-1:0];
    assign frame_len = pad_len(raw_len);
    assign next_pos  = pos + 1'b1;
    assign in_data   = pos < raw_len;

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = stat_q;
        mem_wdata[OWN_BIT] = 1'b0;
        unique case (st)
            S_RD_STAT: mem_en = 1'b1;
            S_RD_LO:   begin mem_en = 1'b1; mem_addr = desc_addr + ADDR_W'(8);  end
            S_RD_HI:   begin mem_en = 1'b1; mem_addr = desc_addr + ADDR_W'(12); end
            S_FETCH:   begin mem_en = 1'b1; mem_addr = {cur_byte[ADDR_W-1:2], 2'b00}; end
            S_WB:      begin mem_en = 1'b1; mem_we = 1'b1; end
            default:   ;
        endcase
    end

    assign tx_valid  = (st == S_SEND);
    assign tx_data   = in_data ? pick_lane(word_q, cur_byte[1:0]) : 8'h00;
    assign tx_last   = (next_pos == frame_len);
    assign take_poll = (st == S_IDLE) && poll_pend;
    assign ok_evt    = (st == S_WB) && seg_ok(stat_q);
    assign err_evt   = (st == S_WB) && !seg_ok(stat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            idx    <= '0;
            stat_q <= '0;
            blo_q  <= '0;
            buf_q  <= '0;
            word_q <= '0;
            pos    <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (base_set) idx <= '0;
                    if (poll_pend) st <= S_RD_STAT;
                end
                S_RD_STAT: st <= S_CAP_STAT;
                S_CAP_STAT: begin
                    stat_q <= mem_rdata;
                    if (!mem_rdata[OWN_BIT])  st <= S_IDLE;
                    else if (!seg_ok(mem_rdata)) st <= S_WB;
                    else                      st <= S_RD_LO;
                end
                S_RD_LO:  st <= S_CAP_LO;
                S_CAP_LO: begin
                    blo_q <= mem_rdata;
                    st    <= S_RD_HI;
                end
                S_RD_HI:  st <= S_CAP_HI;
                S_CAP_HI: begin
                    buf_q <= {mem_rdata, blo_q};
                    pos   <= '0;
                    st    <= (raw_len != '0) ? S_FETCH : S_SEND;
                end
                S_FETCH: st <= S_LOAD;
                S_LOAD: begin
                    word_q <= mem_rdata;
                    st     <= S_SEND;
                end
                S_SEND: begin
                    if (tx_ready) begin
                        pos <= next_pos;
                        if (tx_last)
                            st <= S_WB;
                        else if (next_pos < raw_len && cur_byte[1:0] == 2'b11)
                            st <= S_FETCH;
                    end
                end
                S_WB: begin
                    idx <= stat_q[EOR_BIT] ? '0 : idx + 1'b1;
                    st  <= S_RD_STAT;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
    import txd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [15:0]       int_status,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    logic [ADDR_W-1:0] base;
    logic base_set, poll_pend, take_poll, ok_evt, err_evt;

    txd_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .ok_evt(ok_evt), .err_evt(err_evt), .take_poll(take_poll),
        .base(base), .base_set(base_set), .poll_pend(poll_pend), .isr(int_status)
    );

    txd_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .base(base), .base_set(base_set),
        .poll_pend(poll_pend), .take_poll(take_poll),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .ok_evt(ok_evt), .err_evt(err_evt)
    );
endmodule

// File: rtl/txd_poll_engine_chk.sv
module txd_poll_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] int_status,
    input logic        mem_en,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        tx_ready
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !mem_en && int_status == 16'h0));

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr[1:0] == 2'b00));

    p_hold_stream_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_wb_clears_own_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> !mem_wdata[31]);

    p_last_then_wb_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (mem_en && mem_we));

    p_no_mem_mid_frame_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_en);

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(int_status[3]) |-> !$rose(int_status[2]));
endmodule

bind txd_poll_engine txd_poll_engine_chk u_chk (.*);

// File: tb/txd_poll_engine_bench.sv
module txd_poll_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] int_status;
    logic        mem_en, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    always #4 clk = ~clk;

    txd_poll_engine u_txd_poll_engine (.*);

    // memory model with a bench-side write port
    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    always @(posedge clk) begin
        if (tb_we) mem[tb_wa] <= tb_wd;
        if (mem_en) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    // stream capture and access monitor
    logic [7:0] cap_d [0:8191];
    logic       cap_l [0:8191];
    int cap_n = 0, mem_cnt = 0, hi_bad = 0;
    logic hi_armed = 1'b0;
    always @(posedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            cap_d[cap_n] <= tx_data;
            cap_l[cap_n] <= tx_last;
            cap_n <= cap_n + 1;
        end
        if (!rst && mem_en) begin
            mem_cnt <= mem_cnt + 1;
            if (hi_armed && mem_addr[63:32] != 32'h5) hi_bad <= hi_bad + 1;
        end
    end

    logic stall = 1'b0;
    int   rcnt = 0;
    always @(negedge clk) begin
        rcnt <= rcnt + 1;
        tx_ready <= !stall || (rcnt % 3 != 0);
    end

    int n_chk = 0, n_fail = 0;
    int eidx = 0, kfr = 0;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic poke(input int w, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_wa = 10'(w); tb_wd = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic put_desc(input int i, input logic [31:0] st, input int ba);
        poke(64 + 4*i, st);
        poke(64 + 4*i + 1, 32'h0);
        poke(64 + 4*i + 2, 32'(ba));
        poke(64 + 4*i + 3, 32'h5);
    endtask

    task automatic wait_flag();
        int t;
        t = 0;
        while (int_status[3:2] == 2'b00 && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) check(1'b0, "watchdog frame", t, 0);
        repeat (12) @(negedge clk);
    endtask

    // flags: bits 29/28 to place; EOR added automatically on entry 3
    task automatic run_frame(input int len, input int align, input logic [31:0] segs, input logic stl);
        int ba, c0, n, bad, lastbad, nx;
        logic [31:0] st;
        logic good;
        kfr++;
        stall = stl;
        ba = 32'h400 + (kfr % 20) * 80 + align;
        st = 32'h8000_0000 | segs | 32'(len) | ((eidx == 3) ? 32'h4000_0000 : 32'h0);
        good = segs[29] && segs[28];
        nx = (eidx == 3) ? 0 : eidx + 1;
        put_desc(eidx, st, ba);
        poke(64 + 4*nx, 32'h0);
        c0 = cap_n;
        wreg(8'h38, 32'h40);
        wait_flag();
        n = good ? ((len < 60) ? 60 : len) : 0;
        check(cap_n - c0 == n, good ? "R6 byte count" : "R8 no bytes", cap_n - c0, n);
        bad = 0; lastbad = 0;
        for (int i = 0; i < n; i++) begin
            if (cap_d[c0+i] != ((i < len) ? pat(ba + i) : 8'h00)) bad++;
            if (cap_l[c0+i] != (i == n - 1)) lastbad++;
        end
        if (good) begin
            check(bad == 0, "R5/R6 byte content", bad, 0);
            check(lastbad == 0, "R5 last marker", lastbad, 0);
        end
        check(mem[64 + 4*eidx] == (st & 32'h7FFF_FFFF), good ? "R7 writeback" : "R8 writeback",
              mem[64 + 4*eidx], st & 32'h7FFF_FFFF);
        check(int_status == (good ? 16'h0004 : 16'h0008), good ? "R7 done flag" : "R8 error flag",
              int_status, good ? 4 : 8);
        wreg(8'h3E, 32'h0000_000C);
        @(negedge clk);
        check(int_status == 16'h0, "R10 flag clear", int_status, 0);
        eidx = st[30] ? 0 : eidx + 1;
    endtask

    initial begin
        int c0, m0, tot, bad, ofs;
        int lens [0:10];
        int mlen [0:3];
        lens = '{0, 1, 3, 4, 5, 59, 60, 61, 63, 64, 70};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_valid && !mem_en && int_status == 16'h0, "R1 reset state",
              {tx_valid, mem_en, int_status}, 0);

        for (int w = 256; w < 1024; w++)
            poke(w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
        wreg(8'h24, 32'h5);
        wreg(8'h20, 32'h0000_01FF);
        hi_armed = 1'b1;

        // R2: doorbell without bit 6 does nothing
        put_desc(0, 32'hB000_0040, 32'h400);
        poke(68, 32'h0);
        m0 = mem_cnt; c0 = cap_n;
        wreg(8'h38, 32'h20);
        repeat (30) @(negedge clk);
        check(mem_cnt == m0 && cap_n == c0, "R2 poll bit clear ignored", mem_cnt - m0, 0);

        // R4: entry not owned
        poke(64, 32'h3000_0040);
        m0 = mem_cnt; c0 = cap_n;
        wreg(8'h38, 32'h40);
        repeat (30) @(negedge clk);
        check(cap_n == c0 && int_status == 16'h0, "R4 no bytes no flag", cap_n - c0, 0);
        check(mem[64] == 32'h3000_0040, "R4 status untouched", mem[64], 32'h3000_0040);
        check(mem_cnt - m0 == 1, "R4 single status read", mem_cnt - m0, 1);

        // R5 R6 R7 R9: sweep lengths and alignments, position continues from entry 0
        for (int li = 0; li < 11; li++)
            for (int al = 0; al < 4; al++)
                run_frame(lens[li], al, 32'h3000_0000, (al % 2) == 1);

        // R8: incomplete segment marks
        run_frame(20, 0, 32'h2000_0000, 1'b0);
        run_frame(20, 1, 32'h1000_0000, 1'b0);
        run_frame(20, 2, 32'h0000_0000, 1'b1);
        run_frame(61, 3, 32'h3000_0000, 1'b0);

        // R3 R9: base rewrite resets position; four owned entries walked then wrap stops
        wreg(8'h20, 32'h0000_0100);
        eidx = 0;
        mlen = '{61, 2, 64, 10};
        for (int i = 0; i < 4; i++)
            put_desc(i, 32'hB000_0000 | ((i == 3) ? 32'h4000_0000 : 32'h0) | 32'(mlen[i]),
                     32'h400 + i * 80);
        c0 = cap_n;
        stall = 1'b1;
        wreg(8'h38, 32'h40);
        repeat (1500) @(negedge clk);
        tot = 61 + 60 + 64 + 60;
        check(cap_n - c0 == tot, "R9 ring walk byte total", cap_n - c0, tot);
        bad = 0; ofs = c0;
        for (int i = 0; i < 4; i++) begin
            int n;
            n = (mlen[i] < 60) ? 60 : mlen[i];
            for (int b = 0; b < n; b++)
                if (cap_d[ofs+b] != ((b < mlen[i]) ? pat(32'h400 + i*80 + b) : 8'h00)) bad++;
            ofs += n;
        end
        check(bad == 0, "R9 ring walk order", bad, 0);
        check(mem[64][31] == 1'b0 && mem[76][31] == 1'b0, "R9 all handed back", {mem[64][31], mem[76][31]}, 0);
        wreg(8'h3E, 32'hC);
        run_frame(5, 2, 32'h3000_0000, 1'b0);   // entry 0 after wrap (R9)

        check(hi_bad == 0, "R3 upper address word", hi_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule